// File: doc/BRIEF.md
# Interrupt Acknowledge Bridge Sequencer

The block sits between a CPU that signals an interrupt acknowledge only by its machine-cycle and I/O-request strobes and a family of daisy-chained peripherals that expect two dedicated strobes: an acknowledge level and a read pulse that fetches the vector. When the CPU enters an acknowledge cycle, the block creates both strobes. It also pulls the CPU's wait line low until the vector on the data bus is valid and has met the CPU's setup time.

All timing comes from one clocked shift register that fills with ones while the cycle lasts. Fixed taps on it mark three points: the start of the acknowledge, the fall of the read pulse, and the release of wait. The tap positions are worked out at elaboration from nanosecond minimums, the speed grade, the clock period and the number of peripherals on the chain, so a longer chain gives a longer settle gap and more wait states.

When the peripherals run from a clock of their own, the acknowledge output can be retimed onto that clock through a small synchronizer. The read tap is then moved later by a fixed lag budget. The block decodes no return-from-interrupt instruction. Clearing of in-service flags is left to commands sent to the peripherals.

Top module: `iack_bridge`

## Requirements
- R1: After reset, and in any cycle that follows a clock edge at which `cpu_mcyc_n` was high, `per_rd_n` and `cpu_hold_n` are high (1 = idle). `per_ack_n` is also high once its retiming path has drained.
- R2: A sequence starts at the first clock edge that samples `cpu_mcyc_n`=0, `cpu_ioreq_n`=0 and `cpu_memreq_n`=1. With `cpu_mcyc_n`=1, or with `cpu_memreq_n`=0, an asserted `cpu_ioreq_n` leaves every output high.
- R3: With `SPLIT_CLOCKS`=0, `per_ack_n` falls at the start edge and stays low until the edge after `cpu_mcyc_n` returns high. `per_rd_n` is low only while `per_ack_n` is low.
- R4: `per_rd_n` falls RD_AT clock edges after the start edge. RD_AT = ceil(max(T_gap, CHAIN_LEN*T_link + T_chainsu) / CLK_NS) + (SPLIT_CLOCKS ? PCLK_LAG : 0). The values are T_gap=350/250 ns, T_link=150/100 ns and T_chainsu=120/100 ns for the slow/fast grade.
- R5: `per_rd_n` stays low for RD_LEN = ceil(T_rdw / CLK_NS) cycles, with T_rdw = 350 ns (slow) or 250 ns (fast). It is then released unless the cycle ended first.
- R6: `cpu_hold_n` falls at the start edge and rises DV_CYC = ceil((T_dv + T_cpusu) / CLK_NS) cycles after `per_rd_n` falls. T_dv is 250/180 ns and T_cpusu is 35/30 ns for the slow/fast grade.
- R7: A rising `cpu_mcyc_n` clears the sequence in one edge at any point. `per_rd_n` and `cpu_hold_n` then go high at that edge, and a following cycle restarts with full timing.
- R8: With `SPLIT_CLOCKS`=1, `per_ack_n` passes through `SYNC_STAGES` flops clocked by `pclk` (reset value 1). It falls within 1 to PCLK_LAG CPU-clock cycles after the start edge and rises within PCLK_LAG cycles after the clearing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-side clock |
| rst | input | 1 | Synchronous active-high reset |
| pclk | input | 1 | Peripheral clock; used only when SPLIT_CLOCKS=1 |
| cpu_mcyc_n | input | 1 | CPU machine-cycle strobe, active low |
| cpu_ioreq_n | input | 1 | CPU I/O-request strobe, active low |
| cpu_memreq_n | input | 1 | CPU memory-request strobe, active low |
| per_ack_n | output | 1 | Interrupt-acknowledge level to the peripherals, active low |
| per_rd_n | output | 1 | Vector read pulse to the peripherals, active low |
| cpu_hold_n | output | 1 | Wait request to the CPU, active low |

## Verification
The assertions check on every cycle that a fall of the wait line is always caused by a valid acknowledge condition. They also check that the read pulse sits inside the acknowledge, that it falls exactly RD_AT cycles into the wait, that it never lasts longer than RD_LEN cycles, and that read and wait are idle after any cycle in which the machine-cycle strobe was high. Only the bench scenarios can show the absolute offset of every edge against a requirement-derived schedule, and they do this for both the equal-clock slow-grade build and the split-clock fast-grade build. Those scenarios also cover early aborts before and during the read, back-to-back cycles, and the two ignored strobe patterns.

// File: rtl/iab_pkg.sv
package iab_pkg;

    typedef enum logic {
        GRADE_SLOW = 1'b0,
        GRADE_FAST = 1'b1
    } grade_e;

    // Active-high view of the three generated strobes.
    typedef struct packed {
        logic ack;
        logic rd;
        logic hold;
    } strobe_t;

    function automatic int cycles_for(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int ack_to_rd_ns(input grade_e g);
        return (g == GRADE_FAST) ? 250 : 350;
    endfunction

    function automatic int rd_width_ns(input grade_e g);
        return (g == GRADE_FAST) ? 250 : 350;
    endfunction

    function automatic int vector_valid_ns(input grade_e g);
        return (g == GRADE_FAST) ? 180 : 250;
    endfunction

    function automatic int cpu_setup_ns(input grade_e g);
        return (g == GRADE_FAST) ? 30 : 35;
    endfunction

    function automatic int link_delay_ns(input grade_e g);
        return (g == GRADE_FAST) ? 100 : 150;
    endfunction

    function automatic int chain_setup_ns(input grade_e g);
        return (g == GRADE_FAST) ? 100 : 120;
    endfunction

    // Settle time of the priority chain before the read may start.
    function automatic int settle_ns(input grade_e g, input int links);
        int chain;
        chain = links * link_delay_ns(g) + chain_setup_ns(g);
        return (chain > ack_to_rd_ns(g)) ? chain : ack_to_rd_ns(g);
    endfunction

endpackage

// File: rtl/iab_cycle_detect.sv
module iab_cycle_detect (
    input  logic cpu_mcyc_n,
    input  logic cpu_ioreq_n,
    input  logic cpu_memreq_n,
    output logic start
);
    // Machine cycle plus I/O request with no memory request marks an acknowledge.
    always_comb begin
        start = !cpu_mcyc_n && !cpu_ioreq_n && cpu_memreq_n;
    end
endmodule

// File: rtl/iab_shift_seq.sv
module iab_shift_seq
    import iab_pkg::*;
#(
    parameter int RD_AT    = 72,
    parameter int RD_LEN   = 44,
    parameter int HOLD_END = 108
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    cpu_mcyc_n,
    input  logic    start,
    output strobe_t act
);
    localparam int RD_END = RD_AT + RD_LEN;
    localparam int LAST   = (RD_END > HOLD_END) ? RD_END : HOLD_END;
    localparam int LEN    = LAST + 1;

    logic [LEN-1:0] taps;

    // Ones enter at bit 0 and march upward while the machine cycle lasts.
    always_ff @(posedge clk) begin
        if (rst || cpu_mcyc_n) begin
            taps <= '0;
        end else begin
            taps <= {taps[LEN-2:0], taps[0] | start};
        end
    end

    always_comb begin
        act.ack  = taps[0];
        act.rd   = taps[RD_AT] & ~taps[RD_END];
        act.hold = taps[0] & ~taps[HOLD_END];
    end
endmodule

// File: rtl/iab_ack_retime.sv
module iab_ack_retime #(
    parameter bit SPLIT_CLOCKS = 1'b0,
    parameter int SYNC_STAGES  = 2
) (
    input  logic pclk,
    input  logic rst,
    input  logic ack_in_n,
    output logic ack_out_n
);
    generate
        if (SPLIT_CLOCKS) begin : g_split
            logic [SYNC_STAGES-1:0] stg;
            always_ff @(posedge pclk) begin
                if (rst) begin
                    stg <= '1;
                end else begin
                    stg <= {stg[SYNC_STAGES-2:0], ack_in_n};
                end
            end
            assign ack_out_n = stg[SYNC_STAGES-1];
        end else begin : g_same
            logic unused_pclk;
            assign unused_pclk = pclk ^ rst;
            assign ack_out_n   = ack_in_n;
        end
    endgenerate
endmodule

// File: rtl/iack_bridge.sv
module iack_bridge
    import iab_pkg::*;
#(
    parameter int     CLK_NS       = 8,
    parameter grade_e GRADE        = GRADE_SLOW,
    parameter int     CHAIN_LEN    = 3,
    parameter bit     SPLIT_CLOCKS = 1'b0,
    parameter int     SYNC_STAGES  = 2,
    parameter int     PCLK_LAG     = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic pclk,
    input  logic cpu_mcyc_n,
    input  logic cpu_ioreq_n,
    input  logic cpu_memreq_n,
    output logic per_ack_n,
    output logic per_rd_n,
    output logic cpu_hold_n
);
    localparam int GAP_CYC  = cycles_for(settle_ns(GRADE, CHAIN_LEN), CLK_NS);
    localparam int RD_AT    = GAP_CYC + (SPLIT_CLOCKS ? PCLK_LAG : 0);
    localparam int RD_LEN   = cycles_for(rd_width_ns(GRADE), CLK_NS);
    localparam int DV_CYC   = cycles_for(vector_valid_ns(GRADE) + cpu_setup_ns(GRADE), CLK_NS);
    localparam int HOLD_END = RD_AT + DV_CYC;

    logic    start;
    strobe_t act;

    iab_cycle_detect u_detect (
        .cpu_mcyc_n   (cpu_mcyc_n),
        .cpu_ioreq_n  (cpu_ioreq_n),
        .cpu_memreq_n (cpu_memreq_n),
        .start        (start)
    );

    iab_shift_seq #(
        .RD_AT    (RD_AT),
        .RD_LEN   (RD_LEN),
        .HOLD_END (HOLD_END)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .cpu_mcyc_n (cpu_mcyc_n),
        .start      (start),
        .act        (act)
    );

    iab_ack_retime #(
        .SPLIT_CLOCKS (SPLIT_CLOCKS),
        .SYNC_STAGES  (SYNC_STAGES)
    ) u_retime (
        .pclk      (pclk),
        .rst       (rst),
        .ack_in_n  (~act.ack),
        .ack_out_n (per_ack_n)
    );

    assign per_rd_n   = ~act.rd;
    assign cpu_hold_n = ~act.hold;
endmodule

// File: rtl/iack_bridge_chk.sv
module iack_bridge_chk #(
    parameter int RD_AT  = 72,
    parameter int RD_LEN = 44
) (
    input logic clk,
    input logic rst,
    input logic cpu_mcyc_n,
    input logic cpu_ioreq_n,
    input logic cpu_memreq_n,
    input logic per_ack_n,
    input logic per_rd_n,
    input logic cpu_hold_n
);
    int hold_cnt;
    int rd_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_cnt <= 0;
            rd_cnt   <= 0;
        end else begin
            hold_cnt <= cpu_hold_n ? 0 : hold_cnt + 1;
            rd_cnt   <= per_rd_n ? 0 : rd_cnt + 1;
        end
    end

    p_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(cpu_mcyc_n) |-> (per_rd_n && cpu_hold_n));

    p_start_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(cpu_hold_n) |-> $past(!cpu_mcyc_n && !cpu_ioreq_n && cpu_memreq_n));

    p_rd_in_ack_r3: assert property (@(posedge clk) disable iff (rst)
        !per_rd_n |-> !per_ack_n);

    p_gap_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(per_rd_n) |-> (hold_cnt == RD_AT));

    p_rd_width_r5: assert property (@(posedge clk) disable iff (rst)
        !per_rd_n |-> (rd_cnt < RD_LEN));

    p_hold_at_rd_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(per_rd_n) |-> !cpu_hold_n);
endmodule

bind iack_bridge iack_bridge_chk #(
    .RD_AT  (RD_AT),
    .RD_LEN (RD_LEN)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cpu_mcyc_n   (cpu_mcyc_n),
    .cpu_ioreq_n  (cpu_ioreq_n),
    .cpu_memreq_n (cpu_memreq_n),
    .per_ack_n    (per_ack_n),
    .per_rd_n     (per_rd_n),
    .cpu_hold_n   (cpu_hold_n)
);

// File: tb/iack_bridge_test.sv
module iack_bridge_test;
    import iab_pkg::*;

    localparam int LAG = 10;

    typedef struct {
        string req;
        string ev;
        int    lo;
        int    hi;
    } item_t;

    logic clk = 1'b0;
    logic pclk = 1'b0;
    logic rst = 1'b1;
    logic mcyc_n = 1'b1, ioreq_n = 1'b1, memreq_n = 1'b1;
    logic ack0, rd0, hold0, ack1, rd1, hold1;

    int cyc = 0, t_drive = 0, n_chk = 0, n_bad = 0;
    bit done = 1'b0;
    item_t q0[$];
    item_t q1[$];
    logic pa[2], pr[2], ph[2];

    always #4 clk = ~clk;
    initial begin
        #1;
        forever #12 pclk = ~pclk;
    end
    always @(posedge clk) cyc <= cyc + 1;

    iack_bridge #(.CLK_NS(8), .GRADE(GRADE_SLOW), .CHAIN_LEN(3), .SPLIT_CLOCKS(1'b0)) uut (
        .clk(clk), .rst(rst), .pclk(clk), .cpu_mcyc_n(mcyc_n), .cpu_ioreq_n(ioreq_n),
        .cpu_memreq_n(memreq_n), .per_ack_n(ack0), .per_rd_n(rd0), .cpu_hold_n(hold0));

    iack_bridge #(.CLK_NS(8), .GRADE(GRADE_FAST), .CHAIN_LEN(5), .SPLIT_CLOCKS(1'b1),
                  .SYNC_STAGES(2), .PCLK_LAG(LAG)) uut_x (
        .clk(clk), .rst(rst), .pclk(pclk), .cpu_mcyc_n(mcyc_n), .cpu_ioreq_n(ioreq_n),
        .cpu_memreq_n(memreq_n), .per_ack_n(ack1), .per_rd_n(rd1), .cpu_hold_n(hold1));

    // Requirement-derived schedule, 8 ns clock: uut slow/3 links, uut_x fast/5 links + lag.
    function automatic int cdiv(input int ns);
        return (ns + 7) / 8;
    endfunction
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
    int ra[2], rw[2], dv[2];
    initial begin
        ra[0] = cdiv(imax(350, 3 * 150 + 120));
        rw[0] = cdiv(350);
        dv[0] = cdiv(250 + 35);
        ra[1] = cdiv(imax(250, 5 * 100 + 100)) + LAG;
        rw[1] = cdiv(250);
        dv[1] = cdiv(180 + 30);
    end

    task automatic push(input int u, input string req, input string ev, input int lo, input int hi);
        item_t it;
        it.req = req; it.ev = ev; it.lo = lo; it.hi = hi;
        if (u == 0) q0.push_back(it); else q1.push_back(it);
    endtask

    task automatic take(input int u, input string ev);
        item_t it;
        int off;
        off = cyc - t_drive;
        n_chk++;
        if ((u == 0 && q0.size() == 0) || (u == 1 && q1.size() == 0)) begin
            n_bad++;
            $display("FAIL R2 unit%0d unexpected %s: actual offset %0d expected no event", u, ev, off);
        end else begin
            it = (u == 0) ? q0.pop_front() : q1.pop_front();
            if (it.ev != ev || off < it.lo || off > it.hi) begin
                n_bad++;
                $display("FAIL %s unit%0d: actual %s@%0d expected %s@[%0d,%0d]",
                         it.req, u, ev, off, it.ev, it.lo, it.hi);
            end
        end
    endtask

    task automatic observe(input int u, input logic a, input logic r, input logic h);
        if (ph[u] && !h) take(u, "hold_fall");
        if (pa[u] && !a) take(u, "ack_fall");
        if (pr[u] && !r) take(u, "rd_fall");
        if (!ph[u] && h) take(u, "hold_rise");
        if (!pr[u] && r) take(u, "rd_rise");
        if (!pa[u] && a) take(u, "ack_rise");
        pa[u] = a; pr[u] = r; ph[u] = h;
    endtask

    // Monitor: compares every output edge against the queued schedule.
    always @(negedge clk) begin
        if (!rst && !done) begin
            observe(0, ack0, rd0, hold0);
            observe(1, ack1, rd1, hold1);
        end
    end

    // Driver: one acknowledge cycle with the machine-cycle strobe low for m cycles.
    task automatic ack_cycle(input int m);
        @(negedge clk);
        mcyc_n = 1'b0; ioreq_n = 1'b0; memreq_n = 1'b1;
        t_drive = cyc;
        for (int u = 0; u < 2; u++) begin
            int th, tr, lag;
            lag = (u == 1) ? LAG : 0;
            push(u, "R2", "hold_fall", 1, 1);
            if (u == 0) push(u, "R3", "ack_fall", 1, 1);
            else        push(u, "R8", "ack_fall", 2, 1 + LAG);
            if (m > ra[u]) begin
                push(u, "R4", "rd_fall", 1 + ra[u], 1 + ra[u]);
                th = (m < ra[u] + dv[u]) ? m + 1 : 1 + ra[u] + dv[u];
                tr = (m < ra[u] + rw[u]) ? m + 1 : 1 + ra[u] + rw[u];
                push(u, (th == m + 1) ? "R7" : "R6", "hold_rise", th, th);
                push(u, (tr == m + 1) ? "R7" : "R5", "rd_rise", tr, tr);
            end else begin
                push(u, "R7", "hold_rise", m + 1, m + 1);
            end
            push(u, (u == 1) ? "R8" : "R3", "ack_rise", m + 1, m + 1 + lag);
        end
        repeat (m) @(negedge clk);
        mcyc_n = 1'b1; ioreq_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic check_idle(input string req);
        n_chk++;
        if ({ack0, rd0, hold0} !== 3'b111) begin
            n_bad++;
            $display("FAIL %s uut: actual %b expected 111", req, {ack0, rd0, hold0});
        end
        n_chk++;
        if ({ack1, rd1, hold1} !== 3'b111) begin
            n_bad++;
            $display("FAIL %s uut_x: actual %b expected 111", req, {ack1, rd1, hold1});
        end
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        for (int u = 0; u < 2; u++) begin pa[u] = 1'b1; pr[u] = 1'b1; ph[u] = 1'b1; end
        repeat (8) @(negedge clk);
        check_idle("R1");                 // R1 outputs idle in reset
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check_idle("R1");                 // R1 idle after reset

        ack_cycle(125);                   // full cycle: R3 R4 R5 R6
        ack_cycle(30);                    // abort before read: R7
        ack_cycle(100);                   // abort during read: R7

        // R2: I/O request with machine cycle high is ignored
        @(negedge clk); ioreq_n = 1'b0;
        repeat (10) @(negedge clk);
        check_idle("R2");
        ioreq_n = 1'b1;
        // R2: memory request active blocks the acknowledge
        @(negedge clk); mcyc_n = 1'b0; ioreq_n = 1'b0; memreq_n = 1'b0;
        repeat (10) @(negedge clk);
        check_idle("R2");
        mcyc_n = 1'b1; ioreq_n = 1'b1; memreq_n = 1'b1;
        repeat (12) @(negedge clk);

        ack_cycle(200);                   // long hold: R5 R6
        ack_cycle(60);                    // R7
        for (int k = 0; k < 3; k++) ack_cycle(125 + k);   // back-to-back restart R7

        check_idle("R1");
        n_chk++;
        if (q0.size() != 0 || q1.size() != 0) begin
            n_bad++;
            $display("FAIL R4 missing events: actual %0d/%0d pending expected 0/0", q0.size(), q1.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule